// File: doc/BRIEF.md
# Interleaved-Slice Sparse Matrix-Vector Engine

This block forms y = A·x for a sparse matrix streamed in a sliced, zero-padded ELL layout. The rows are grouped into slices of L consecutive rows, where L is also the depth of the pipelined adder in the accumulation loop. Inside a slice every row is padded with zero-valued entries up to the length of the slice's longest row. The slice is sent transposed, so consecutive beats belong to consecutive rows. Each row's partial sum therefore comes back out of the adder ring exactly when that row's next element arrives, and the engine takes one element per cycle without stalling.

Before streaming, the dense vector x is written into an on-chip buffer through a plain write port. Each slice begins with one header beat that gives its width W. The L·W data beats follow, each carrying a value and a column index. When the last beat of a slice has been taken, the input closes and the L row sums leave on a result stream, in row order, each tagged with its global row index. Rows at or beyond `num_rows` are dropped from the output. After the slice that covers the last row, the row numbering returns to zero for the next matrix.

Both streams use valid/ready. A beat moves on a cycle where valid and ready are both high. A source that raises valid holds its beat until it is accepted. The engine holds `res_valid`, `res_row` and `res_sum` steady while `res_ready` is low.

Top module: `spmv_sell_engine`

## Requirements
- R1: A cycle with `x_we` high stores `x_wdata` at entry `x_addr` of the vector buffer. A matrix beat reads the buffer at entry `mat_col[XAW-1:0]`.
- R2: After reset, and after every slice's result phase, the next accepted matrix beat is a header whose `mat_col` gives the slice width W. Exactly L·W data beats then follow.
- R3: Data beat k of a slice (counting from 0) belongs to local row k mod L. The row's sum is the sum of `mat_val`·x[col] over its beats, in AW-bit two's complement, with each signed DW×DW product sign-extended.
- R4: A data beat whose `mat_val` is zero leaves every row sum unchanged, whatever its column index.
- R5: `mat_ready` stays high through the header and data phases. When valid is held high, the L·W data beats of a slice are accepted in L·W consecutive cycles.
- R6: After the last data beat, `mat_ready` is low until the slice's results are done. The sums leave in local row order 0..L-1, tagged with row index base+i.
- R7: A slice with W = 0 emits a zero sum for each of its real rows.
- R8: A row whose global index is at or above `num_rows` produces no result beat. After the slice containing row `num_rows`-1, the base row index returns to 0.
- R9: While `res_valid` is high and `res_ready` is low, `res_valid`, `res_row` and `res_sum` hold their values.
- R10: After reset, `mat_ready` is 1, `res_valid` is 0 and the base row index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| num_rows | input | RW | Real row count of the current matrix; hold stable while streaming |
| x_we | input | 1 | Vector buffer write enable |
| x_addr | input | XAW | Vector buffer write address |
| x_wdata | input | DW | Vector element, signed |
| mat_valid | input | 1 | Matrix beat valid |
| mat_ready | output | 1 | Matrix beat ready |
| mat_val | input | DW | Signed matrix value (ignored on a header) |
| mat_col | input | CW | Column index on data beats; slice width W on a header |
| res_valid | output | 1 | Result beat valid |
| res_ready | input | 1 | Result beat ready |
| res_row | output | RW | Global row index of the result |
| res_sum | output | AW | Signed row sum |

## Verification
A lane counter that slips against the adder ring adds an element into a neighbouring row. Because sums leave strictly in row order, the error shows in the first result of the same slice, within L·W+L cycles of the slip. A wrong width or beat count leaves the engine reading a data beat as a header, or the reverse. The slice after it then gives wrong sums or an early result phase. A wrong base or phantom decision shows as a misnumbered or surplus result. The result may appear as soon as the first drain, or only after the boundary back to row 0.

// File: rtl/spmv_pkg.sv
package spmv_pkg;
  typedef enum logic [1:0] {
    PH_HEAD  = 2'd0,
    PH_BEATS = 2'd1,
    PH_DRAIN = 2'd2
  } phase_t;

  function automatic int unsigned idx_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/spmv_xbuf.sv
module spmv_xbuf #(
  parameter int DW    = 12,
  parameter int DEPTH = 16,
  localparam int XAW  = spmv_pkg::idx_bits(DEPTH)
) (
  input  logic           clk,
  input  logic           wr_en,
  input  logic [XAW-1:0] wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic [XAW-1:0] rd_addr,
  output logic [DW-1:0]  rd_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/spmv_acc_ring.sv
module spmv_acc_ring #(
  parameter int L  = 4,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          restart,
  input  logic [AW-1:0] addend,
  output logic [AW-1:0] tail
);
  logic [AW-1:0] stage [L];

  always_ff @(posedge clk) begin
    if (!rst_n)   stage[0] <= '0;
    else if (adv) stage[0] <= (restart ? '0 : stage[L-1]) + addend;
  end

  for (genvar i = 1; i < L; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n)   stage[i] <= '0;
      else if (adv) stage[i] <= stage[i-1];
    end
  end

  assign tail = stage[L-1];
endmodule

// File: rtl/spmv_seq.sv
module spmv_seq #(
  parameter int L  = 4,
  parameter int CW = 5,
  parameter int RW = 8,
  localparam int LW = spmv_pkg::idx_bits(L),
  localparam int BW = CW + LW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] num_rows,
  input  logic          mat_valid,
  input  logic [CW-1:0] mat_col,
  input  logic          res_ready,
  output logic          mat_ready,
  output logic          beat_fire,
  output logic          first_col,
  output logic          drain_step,
  output logic          res_valid,
  output logic [RW-1:0] res_row,
  output logic          empty_slice
);
  import spmv_pkg::*;
  localparam logic [LW-1:0] LAST_LANE = LW'(L - 1);

  phase_t        phase;
  logic [LW-1:0] lane, didx;
  logic [CW-1:0] wpos, wlen;
  logic [RW-1:0] base;
  logic          head_fire, last_beat, real_row;
  logic [RW:0]   row_wide, next_base_wide;

  assign mat_ready  = (phase != PH_DRAIN);
  assign head_fire  = mat_valid && (phase == PH_HEAD);
  assign beat_fire  = mat_valid && (phase == PH_BEATS);
  assign first_col  = (wpos == '0);
  assign last_beat  = (lane == LAST_LANE) && (wpos == wlen - CW'(1));

  assign row_wide       = {1'b0, base} + (RW+1)'(didx);
  assign next_base_wide = {1'b0, base} + (RW+1)'(L);
  assign real_row       = row_wide < {1'b0, num_rows};
  assign res_valid      = (phase == PH_DRAIN) && real_row;
  assign drain_step     = (phase == PH_DRAIN) && (!real_row || res_ready);
  assign res_row        = row_wide[RW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase       <= PH_HEAD;
      lane        <= '0;
      didx        <= '0;
      wpos        <= '0;
      wlen        <= '0;
      base        <= '0;
      empty_slice <= 1'b0;
    end else begin
      unique case (phase)
        PH_HEAD: if (head_fire) begin
          wlen        <= mat_col;
          wpos        <= '0;
          lane        <= '0;
          didx        <= '0;
          empty_slice <= (mat_col == '0);
          phase       <= (mat_col == '0) ? PH_DRAIN : PH_BEATS;
        end
        PH_BEATS: if (beat_fire) begin
          if (lane == LAST_LANE) begin
            lane <= '0;
            wpos <= wpos + CW'(1);
          end else begin
            lane <= lane + LW'(1);
          end
          if (last_beat) phase <= PH_DRAIN;
        end
        PH_DRAIN: if (drain_step) begin
          if (didx == LAST_LANE) begin
            phase <= PH_HEAD;
            base  <= (next_base_wide >= {1'b0, num_rows}) ? '0 : next_base_wide[RW-1:0];
          end else begin
            didx <= didx + LW'(1);
          end
        end
        default: phase <= PH_HEAD;
      endcase
    end
  end

  // independent tally of data beats, cleared by each header
  logic [BW-1:0] beats_seen;
  always_ff @(posedge clk) begin
    if (!rst_n)         beats_seen <= '0;
    else if (head_fire) beats_seen <= '0;
    else if (beat_fire) beats_seen <= beats_seen + BW'(1);
  end

  a_r2_beat_count: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && last_beat) |-> (beats_seen + BW'(1) == BW'(L) * BW'(wlen)));

  a_r8_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_row < num_rows));
endmodule

// File: rtl/spmv_sell_engine.sv
module spmv_sell_engine #(
  parameter int L      = 4,
  parameter int DW     = 12,
  parameter int AW     = 32,
  parameter int XDEPTH = 16,
  parameter int RW     = 8,
  localparam int XAW   = spmv_pkg::idx_bits(XDEPTH),
  localparam int CW    = XAW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [RW-1:0]  num_rows,
  input  logic           x_we,
  input  logic [XAW-1:0] x_addr,
  input  logic [DW-1:0]  x_wdata,
  input  logic           mat_valid,
  output logic           mat_ready,
  input  logic [DW-1:0]  mat_val,
  input  logic [CW-1:0]  mat_col,
  output logic           res_valid,
  input  logic           res_ready,
  output logic [RW-1:0]  res_row,
  output logic [AW-1:0]  res_sum
);
  logic [DW-1:0]          x_rd;
  logic signed [2*DW-1:0] prod;
  logic [AW-1:0]          addend, tail;
  logic beat_fire, first_col, drain_step, empty_slice;

  spmv_xbuf #(.DW(DW), .DEPTH(XDEPTH)) u_xbuf (
    .clk(clk), .wr_en(x_we), .wr_addr(x_addr), .wr_data(x_wdata),
    .rd_addr(mat_col[XAW-1:0]), .rd_data(x_rd)
  );

  assign prod   = $signed(mat_val) * $signed(x_rd);
  assign addend = AW'(prod);

  spmv_seq #(.L(L), .CW(CW), .RW(RW)) u_seq (
    .clk(clk), .rst_n(rst_n), .num_rows(num_rows),
    .mat_valid(mat_valid), .mat_col(mat_col), .res_ready(res_ready),
    .mat_ready(mat_ready), .beat_fire(beat_fire), .first_col(first_col),
    .drain_step(drain_step), .res_valid(res_valid), .res_row(res_row),
    .empty_slice(empty_slice)
  );

  spmv_acc_ring #(.L(L), .AW(AW)) u_ring (
    .clk(clk), .rst_n(rst_n), .adv(beat_fire || drain_step),
    .restart(first_col), .addend(addend), .tail(tail)
  );

  assign res_sum = empty_slice ? '0 : tail;

  // result ordering monitor
  logic          seen;
  logic [RW-1:0] last_row;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen     <= 1'b0;
      last_row <= '0;
    end else if (res_valid && res_ready) begin
      seen     <= 1'b1;
      last_row <= res_row;
    end
  end

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_row) && $stable(res_sum)));

  a_r6_row_order: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && seen) |-> ((res_row == last_row + RW'(1)) || (res_row == '0)));

  a_r6_input_closed: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !mat_ready);
endmodule

// File: tb/sim_spmv_sell_engine.sv
module sim_spmv_sell_engine;
  localparam int CLK_NS = 10;
  localparam int L = 4, DW = 12, AW = 32, XD = 16, RW = 8, XAW = 4, CW = 5;
  localparam int MAXR = 32;

  logic clk = 0, rst_n = 0;
  logic [RW-1:0] num_rows = 1;
  logic x_we = 0; logic [XAW-1:0] x_addr = 0; logic [DW-1:0] x_wdata = 0;
  logic mat_valid = 0; logic mat_ready; logic [DW-1:0] mat_val = 0; logic [CW-1:0] mat_col = 0;
  logic res_valid; logic res_ready = 0; logic [RW-1:0] res_row; logic [AW-1:0] res_sum;

  always #(CLK_NS/2) clk = ~clk;

  spmv_sell_engine #(.L(L), .DW(DW), .AW(AW), .XDEPTH(XD), .RW(RW)) u0 (.*);

  int checks = 0, fails = 0, cyc = 0;
  int A [MAXR][XD];
  int xv [XD];
  int expv [MAXR];
  int nrows;
  bit nogap;

  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_x();
    for (int c = 0; c < XD; c++) begin
      @(negedge clk);
      xv[c] = int'($urandom % 4095) - 2047;
      x_we = 1; x_addr = XAW'(c); x_wdata = DW'(xv[c]);
    end
    @(negedge clk); x_we = 0;
  endtask

  function automatic void gen(input int n, input int dens, input int empty_sl);
    for (int r = 0; r < MAXR; r++)
      for (int c = 0; c < XD; c++) begin
        A[r][c] = 0;
        if (r < n && int'($urandom % 100) < dens && (r / L) != empty_sl) begin
          A[r][c] = int'($urandom % 4095) - 2047;
          if (A[r][c] == 0) A[r][c] = 1;
        end
      end
    nrows = n;
    for (int r = 0; r < MAXR; r++) begin
      expv[r] = 0;
      for (int c = 0; c < XD; c++) expv[r] += A[r][c] * xv[c];
    end
  endfunction

  function automatic int nnz(input int r);
    int k = 0;
    if (r >= nrows) return 0;
    for (int c = 0; c < XD; c++) if (A[r][c] != 0) k++;
    return k;
  endfunction

  // beat is accepted at the posedge following the cycle in which ready is seen
  task automatic push(input int v, input int col, output int acc_cyc);
    if (!nogap && ($urandom % 4) == 0) begin mat_valid = 0; @(negedge clk); end
    mat_valid = 1; mat_val = DW'(v); mat_col = CW'(col);
    #1;
    while (!mat_ready) begin @(negedge clk); #1; end
    acc_cyc = cyc;
    @(negedge clk);
    mat_valid = 0;
  endtask

  task automatic drive();
    int t, t0, t1, w, k, pos, r, cc;
    for (int s = 0; s * L < nrows; s++) begin
      w = 0;
      for (int ln = 0; ln < L; ln++) if (nnz(s*L+ln) > w) w = nnz(s*L+ln);
      push(int'($urandom % 100), w, t);
      for (pos = 0; pos < w; pos++)
        for (int ln = 0; ln < L; ln++) begin
          r = s*L + ln; k = 0; cc = -1;
          if (r < nrows)
            for (int c = 0; c < XD; c++)
              if (A[r][c] != 0) begin
                if (k == pos) cc = c;
                k++;
              end
          if (nogap) begin mat_valid = 1; end
          if (cc >= 0) push(A[r][cc], cc, t);
          else push(0, int'($urandom % XD), t);   // R4 padding: zero value, arbitrary column
          if (pos == 0 && ln == 0) t0 = t;
          t1 = t;
        end
      if (nogap && w > 0) check(t1 - t0 == L*w - 1, "R5 back-to-back beats", t1 - t0, L*w - 1);
    end
  endtask

  task automatic collect();
    int got = 0;
    while (got < nrows) begin
      @(negedge clk);
      res_ready = nogap ? 1'b1 : (($urandom % 4) != 0);
      #1;
      if (res_valid && res_ready) begin
        check(res_row == RW'(got), "R6 R8 row index", res_row, got);
        check($signed(res_sum) == expv[got], "R3 R4 R7 row sum", $signed(res_sum), expv[got]);
        got++;
      end
    end
    @(negedge clk); res_ready = 1;
    repeat (3 * L) begin
      @(negedge clk); #1;
      if (res_valid) check(0, "R8 phantom row emitted", res_row, -1);
    end
    check(mat_ready == 1 && !res_valid, "R2 R8 header expected at row 0", mat_ready, 1);
  endtask

  task automatic run_one(input int n, input int dens, input int empty_sl, input bit ng);
    nogap = ng;
    load_x();
    gen(n, dens, empty_sl);
    num_rows = RW'(n);
    fork
      drive();
      collect();
    join
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk);
    #1;
    check(mat_ready == 1, "R10 ready after reset", mat_ready, 1);
    check(res_valid == 0, "R10 no result after reset", res_valid, 0);
    @(negedge clk); rst_n = 1;
    run_one(8, 50, -1, 1);        // R1 R5 directed, no gaps
    run_one(10, 40, 1, 0);        // R7 empty slice, R8 phantom rows
    run_one(1, 80, -1, 0);        // single real row
    run_one(4, 100, -1, 1);       // full-width rows
    run_one(7, 0, -1, 0);         // all slices W=0
    for (int i = 0; i < 8; i++)
      run_one(1 + int'($urandom % MAXR), 10 + int'($urandom % 81), -1, 0);
  endtask

  initial begin
    bit timeout = 0;
    void'($urandom(32'h5EED_2024));
    fork
      run_all();
      begin repeat (150000) @(posedge clk); timeout = 1; end
    join_any
    disable fork;
    if (timeout) check(0, "watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule